// File: doc/BRIEF.md
# Linked-List Sharer Update Node

This block is the coherence logic one cache keeps for an update-based protocol in which the sharers of a line form a singly linked chain. The home directory remembers only which cache heads the chain. For each line, this node keeps a present bit, a head flag, a tail flag, the ID of its successor and a small register file of data words. When an update message arrives, the node writes the new word into its copy. A middle node then passes the update on to its successor. The last node in the chain instead returns an acknowledgment straight to the cache that wrote the word.

A local write hit is applied to the node's own copy first. If the node heads the chain, it launches the update at its successor itself. If it does not, it sends the write to the directory, which starts the update at the head. A node that is both head and tail holds the only copy, so its write is performed at once and nothing is sent. A writer counts its outstanding writes and reports them performed when the count is back at zero.

Joining a chain works like this. Local link control makes the node the new head and records its successor. A request from a newer joiner reaches the current head, which gives up the head role and answers with a grant. The network is modelled as one inbound and one outbound message port.

The control is a four-state machine. It has these states:
- ST_IDLE accepts one inbound message, which has priority, or one local write.
- ST_MSG handles an inbound message.
- ST_LOCAL handles a local write.
- ST_SEND drives the outbound message for one cycle.

The transitions are:
- accept_msg: ST_IDLE to ST_MSG.
- accept_write: ST_IDLE to ST_LOCAL.
- emit: ST_MSG or ST_LOCAL to ST_SEND, when a message must go out.
- settle: ST_MSG or ST_LOCAL to ST_IDLE, when no message goes out.
- drain: ST_SEND to ST_IDLE.

Top module: `sharer_node`

## Requirements
- R1: After reset, out_valid is 0, pending is 0, performed is 1, in_ready and wr_ready are 1, and every line reads back with rd_valid 0.
- R2: A link_valid pulse marks the line present and makes this node its head. It records link_next as the successor, sets the tail flag to link_alone and clears every data word of the line to zero.
- R3: A local write to a present line where this node is head but not tail stores the word. It sends kind 0 (update) to the successor with origin = NODE_ID and the written line, offset and data. It also raises pending by one, so performed drops to 0.
- R4: A local write to a present line where this node is not head stores the word. It sends kind 2 (write) to DIR_ID with origin = NODE_ID and the written line, offset and data, and raises pending by one.
- R5: A local write to a present line where this node is both head and tail stores the word, sends nothing and leaves pending unchanged.
- R6: An inbound kind 0 for a present, non-tail line stores the word. It forwards kind 0 to the successor and keeps the origin, line, offset and data unchanged.
- R7: An inbound kind 0 for a present tail line whose origin is not NODE_ID stores the word. It sends kind 1 (acknowledge) to the origin and carries the origin, line, offset and data.
- R8: An inbound kind 0 for a present tail line whose origin equals NODE_ID stores the word. It sends nothing and lowers pending by one.
- R9: An inbound kind 1 lowers pending by one. performed is 1 exactly when pending is 0.
- R10: An inbound kind 3 (join request) for a line this node heads clears the head flag. It answers with kind 4 (grant) to the requester in_src, carrying the request's line, offset and data, with origin = NODE_ID. For a line it does not head, the request has no effect.
- R11: A local write or an inbound update for a line that is not present changes no stored word, sends nothing and leaves pending unchanged.
- R12: in_ready is 1 only in ST_IDLE. wr_ready is 1 only in ST_IDLE with in_valid low. An outbound message is valid for exactly one cycle, which starts two clock edges after the request was accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| link_valid | input | 1 | Join the chain for link_line as its new head |
| link_line | input | LINE_W | Line being joined |
| link_next | input | NODE_W | Successor node ID |
| link_alone | input | 1 | No successor: this node is also the tail |
| wr_valid | input | 1 | Local write hit request |
| wr_ready | output | 1 | Local write accepted this cycle |
| wr_line | input | LINE_W | Line of the local write |
| wr_off | input | OFF_W | Word offset of the local write |
| wr_data | input | DATA_W | Local write data |
| rd_line | input | LINE_W | Read port line |
| rd_off | input | OFF_W | Read port word offset |
| rd_valid | output | 1 | Read line is present |
| rd_data | output | DATA_W | Stored word |
| in_valid | input | 1 | Inbound message present |
| in_ready | output | 1 | Inbound message accepted this cycle |
| in_kind | input | 3 | Inbound message kind |
| in_src | input | NODE_W | Sender node ID |
| in_origin | input | NODE_W | Writer node ID |
| in_line | input | LINE_W | Message line |
| in_off | input | OFF_W | Message word offset |
| in_data | input | DATA_W | Message data |
| out_valid | output | 1 | Outbound message present |
| out_kind | output | 3 | Outbound message kind |
| out_dst | output | NODE_W | Destination node ID |
| out_origin | output | NODE_W | Writer node ID |
| out_line | output | LINE_W | Message line |
| out_off | output | OFF_W | Message word offset |
| out_data | output | DATA_W | Message data |
| pending | output | CNT_W | Outstanding own writes |
| performed | output | 1 | No own write is outstanding |

## Verification
The assertions assume certain things about the traffic and the link control:
- An acknowledgment never arrives while pending is zero.
- A node never has MAX_PEND writes outstanding.
- link_next never names this node, so an update is never forwarded to itself.
- Link pulses never collide with processing of the same line.

The stimulus stays inside these limits. Every acknowledgment answers an earlier write, and at most two writes are outstanding at a time. Successors are always other IDs or the directory, and each request is issued only after the previous one has fully drained.

// File: rtl/sharer_pkg.sv
package sharer_pkg;

    typedef enum logic [2:0] {
        MSG_UPD   = 3'd0,
        MSG_ACK   = 3'd1,
        MSG_WRITE = 3'd2,
        MSG_REQ   = 3'd3,
        MSG_GRANT = 3'd4
    } msg_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_MSG,
        ST_LOCAL,
        ST_SEND
    } node_state_e;

endpackage

// File: rtl/sharer_line_table.sv
module sharer_line_table #(
    parameter int LINES  = 4,
    parameter int NODE_W = 3,
    localparam int LINE_W = $clog2(LINES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              link_en,
    input  logic [LINE_W-1:0] link_line,
    input  logic [NODE_W-1:0] link_next,
    input  logic              link_alone,
    input  logic              unhead_en,
    input  logic [LINE_W-1:0] unhead_line,
    input  logic [LINE_W-1:0] look_line,
    output logic              look_valid,
    output logic              look_head,
    output logic              look_tail,
    output logic [NODE_W-1:0] look_next,
    output logic [LINES-1:0]  valid_vec
);

    logic [LINES-1:0]  head_vec;
    logic [LINES-1:0]  tail_vec;
    logic [NODE_W-1:0] next_arr [LINES];

    // One entry of chain state per line
    for (genvar l = 0; l < LINES; l++) begin : g_line
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                valid_vec[l] <= 1'b0;
                head_vec[l]  <= 1'b0;
                tail_vec[l]  <= 1'b0;
                next_arr[l]  <= '0;
            end else if (link_en && link_line == LINE_W'(l)) begin
                valid_vec[l] <= 1'b1;
                head_vec[l]  <= 1'b1;
                tail_vec[l]  <= link_alone;
                next_arr[l]  <= link_next;
            end else if (unhead_en && unhead_line == LINE_W'(l)) begin
                head_vec[l]  <= 1'b0;
            end
        end
    end

    assign look_valid = valid_vec[look_line];
    assign look_head  = head_vec[look_line];
    assign look_tail  = tail_vec[look_line];
    assign look_next  = next_arr[look_line];

    AST_LINK_MAKES_HEAD: assert property (@(posedge clk) disable iff (!rst_n)
        link_en |=> (head_vec[$past(link_line)] && valid_vec[$past(link_line)])); // R2

endmodule

// File: rtl/sharer_word_store.sv
module sharer_word_store #(
    parameter int LINES  = 4,
    parameter int WORDS  = 4,
    parameter int DATA_W = 16,
    localparam int LINE_W = $clog2(LINES),
    localparam int OFF_W  = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_en,
    input  logic [LINE_W-1:0] clr_line,
    input  logic              we,
    input  logic [LINE_W-1:0] w_line,
    input  logic [OFF_W-1:0]  w_off,
    input  logic [DATA_W-1:0] w_data,
    input  logic [LINE_W-1:0] rd_line,
    input  logic [OFF_W-1:0]  rd_off,
    output logic [DATA_W-1:0] rd_data
);

    logic [DATA_W-1:0] mem [LINES][WORDS];

    for (genvar l = 0; l < LINES; l++) begin : g_line
        for (genvar w = 0; w < WORDS; w++) begin : g_word
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    mem[l][w] <= '0;
                end else if (clr_en && clr_line == LINE_W'(l)) begin
                    mem[l][w] <= '0;
                end else if (we && w_line == LINE_W'(l) && w_off == OFF_W'(w)) begin
                    mem[l][w] <= w_data;
                end
            end
        end
    end

    assign rd_data = mem[rd_line][rd_off];

endmodule

// File: rtl/sharer_write_tracker.sv
module sharer_write_tracker #(
    parameter int MAX_PEND = 7,
    localparam int CNT_W = $clog2(MAX_PEND + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    input  logic             dec,
    output logic [CNT_W-1:0] count,
    output logic             performed
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else if (inc && !dec && count != CNT_W'(MAX_PEND)) begin
            count <= count + 1'b1;
        end else if (dec && !inc && count != '0) begin
            count <= count - 1'b1;
        end
    end

    assign performed = (count == '0);

    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        dec |-> (count != '0)); // R9
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        inc |-> (count != CNT_W'(MAX_PEND))); // R3
    AST_INC_CLEARS_PERFORMED: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !dec) |=> !performed); // R3

endmodule

// File: rtl/sharer_node.sv
module sharer_node
    import sharer_pkg::*;
#(
    parameter int NODE_W   = 3,
    parameter int NODE_ID  = 2,
    parameter int DIR_ID   = 0,
    parameter int LINES    = 4,
    parameter int WORDS    = 4,
    parameter int DATA_W   = 16,
    parameter int MAX_PEND = 7,
    localparam int LINE_W  = $clog2(LINES),
    localparam int OFF_W   = $clog2(WORDS),
    localparam int CNT_W   = $clog2(MAX_PEND + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              link_valid,
    input  logic [LINE_W-1:0] link_line,
    input  logic [NODE_W-1:0] link_next,
    input  logic              link_alone,
    input  logic              wr_valid,
    output logic              wr_ready,
    input  logic [LINE_W-1:0] wr_line,
    input  logic [OFF_W-1:0]  wr_off,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [LINE_W-1:0] rd_line,
    input  logic [OFF_W-1:0]  rd_off,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [2:0]        in_kind,
    input  logic [NODE_W-1:0] in_src,
    input  logic [NODE_W-1:0] in_origin,
    input  logic [LINE_W-1:0] in_line,
    input  logic [OFF_W-1:0]  in_off,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_valid,
    output logic [2:0]        out_kind,
    output logic [NODE_W-1:0] out_dst,
    output logic [NODE_W-1:0] out_origin,
    output logic [LINE_W-1:0] out_line,
    output logic [OFF_W-1:0]  out_off,
    output logic [DATA_W-1:0] out_data,
    output logic [CNT_W-1:0]  pending,
    output logic              performed
);

    localparam logic [NODE_W-1:0] SELF = NODE_W'(NODE_ID);
    localparam logic [NODE_W-1:0] DIR  = NODE_W'(DIR_ID);

    node_state_e state_q, state_d;

    msg_kind_e         lat_kind;
    logic [NODE_W-1:0] lat_src, lat_origin;
    logic [LINE_W-1:0] lat_line;
    logic [OFF_W-1:0]  lat_off;
    logic [DATA_W-1:0] lat_data;

    logic              look_valid, look_head, look_tail;
    logic [NODE_W-1:0] look_next;
    logic [LINES-1:0]  valid_vec;

    logic              emit, store_we, cnt_inc, cnt_dec, unhead;
    msg_kind_e         e_kind;
    logic [NODE_W-1:0] e_dst, e_origin;
    msg_kind_e         out_kind_q;

    sharer_line_table #(.LINES(LINES), .NODE_W(NODE_W)) u_table (
        .clk(clk), .rst_n(rst_n),
        .link_en(link_valid), .link_line(link_line),
        .link_next(link_next), .link_alone(link_alone),
        .unhead_en(unhead), .unhead_line(lat_line),
        .look_line(lat_line), .look_valid(look_valid), .look_head(look_head),
        .look_tail(look_tail), .look_next(look_next), .valid_vec(valid_vec)
    );

    sharer_word_store #(.LINES(LINES), .WORDS(WORDS), .DATA_W(DATA_W)) u_store (
        .clk(clk), .rst_n(rst_n),
        .clr_en(link_valid), .clr_line(link_line),
        .we(store_we), .w_line(lat_line), .w_off(lat_off), .w_data(lat_data),
        .rd_line(rd_line), .rd_off(rd_off), .rd_data(rd_data)
    );

    sharer_write_tracker #(.MAX_PEND(MAX_PEND)) u_tracker (
        .clk(clk), .rst_n(rst_n), .inc(cnt_inc), .dec(cnt_dec),
        .count(pending), .performed(performed)
    );

    assign rd_valid = valid_vec[rd_line];

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Request latch and outbound message register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lat_kind   <= MSG_UPD;
            lat_src    <= '0;
            lat_origin <= '0;
            lat_line   <= '0;
            lat_off    <= '0;
            lat_data   <= '0;
            out_kind_q <= MSG_UPD;
            out_dst    <= '0;
            out_origin <= '0;
            out_line   <= '0;
            out_off    <= '0;
            out_data   <= '0;
        end else begin
            if (state_q == ST_IDLE) begin
                if (in_valid) begin
                    lat_kind   <= msg_kind_e'(in_kind);
                    lat_src    <= in_src;
                    lat_origin <= in_origin;
                    lat_line   <= in_line;
                    lat_off    <= in_off;
                    lat_data   <= in_data;
                end else if (wr_valid) begin
                    lat_kind   <= MSG_WRITE;
                    lat_src    <= SELF;
                    lat_origin <= SELF;
                    lat_line   <= wr_line;
                    lat_off    <= wr_off;
                    lat_data   <= wr_data;
                end
            end
            if (emit) begin
                out_kind_q <= e_kind;
                out_dst    <= e_dst;
                out_origin <= e_origin;
                out_line   <= lat_line;
                out_off    <= lat_off;
                out_data   <= lat_data;
            end
        end
    end

    // Next state and per-request decisions
    always_comb begin
        state_d  = state_q;
        emit     = 1'b0;
        store_we = 1'b0;
        cnt_inc  = 1'b0;
        cnt_dec  = 1'b0;
        unhead   = 1'b0;
        e_kind   = MSG_UPD;
        e_dst    = '0;
        e_origin = SELF;
        unique case (state_q)
            ST_IDLE: begin
                if (in_valid)      state_d = ST_MSG;    // accept_msg
                else if (wr_valid) state_d = ST_LOCAL;  // accept_write
            end
            ST_LOCAL: begin
                if (look_valid) begin
                    store_we = 1'b1;
                    if (look_head && !look_tail) begin
                        emit = 1'b1; cnt_inc = 1'b1;
                        e_kind = MSG_UPD; e_dst = look_next;
                    end else if (!look_head) begin
                        emit = 1'b1; cnt_inc = 1'b1;
                        e_kind = MSG_WRITE; e_dst = DIR;
                    end
                end
                state_d = emit ? ST_SEND : ST_IDLE;     // emit / settle
            end
            ST_MSG: begin
                unique case (lat_kind)
                    MSG_UPD: begin
                        if (look_valid) begin
                            store_we = 1'b1;
                            if (!look_tail) begin
                                emit = 1'b1; e_kind = MSG_UPD;
                                e_dst = look_next; e_origin = lat_origin;
                            end else if (lat_origin == SELF) begin
                                cnt_dec = 1'b1;
                            end else begin
                                emit = 1'b1; e_kind = MSG_ACK;
                                e_dst = lat_origin; e_origin = lat_origin;
                            end
                        end
                    end
                    MSG_ACK: cnt_dec = 1'b1;
                    MSG_REQ: begin
                        if (look_valid && look_head) begin
                            unhead = 1'b1; emit = 1'b1;
                            e_kind = MSG_GRANT; e_dst = lat_src;
                        end
                    end
                    default: ;
                endcase
                state_d = emit ? ST_SEND : ST_IDLE;     // emit / settle
            end
            ST_SEND: state_d = ST_IDLE;                 // drain
            default: state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        out_valid = (state_q == ST_SEND);
        out_kind  = out_kind_q;
        in_ready  = (state_q == ST_IDLE);
        wr_ready  = (state_q == ST_IDLE) && !in_valid;
    end

    AST_SEND_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid); // R12
    AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> !in_ready); // R12
    AST_SOLE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOCAL && look_valid && look_head && look_tail) |=> !out_valid); // R5
    AST_NO_SELF_FORWARD: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_kind == MSG_UPD) |-> (out_dst != SELF)); // R6

endmodule

// File: tb/sharer_node_bench.sv
module sharer_node_bench;

    typedef struct packed {
        logic [1:0]  op;       // 0 link, 1 local write, 2 inbound message
        logic [2:0]  kind;
        logic [2:0]  src;
        logic [2:0]  origin;
        logic [1:0]  line;
        logic [1:0]  off;
        logic [15:0] data;
        logic [2:0]  nxt;
        logic        alone;
        logic        exp_out;
        logic [2:0]  exp_kind;
        logic [2:0]  exp_dst;
        logic [2:0]  exp_org;
        logic [2:0]  exp_pend;
        logic        exp_rdv;
        logic [15:0] exp_rd;
        logic [7:0]  rq;
    } vec_t;

    localparam int NV = 17;
    localparam vec_t VECS [NV] = '{
        '{0, 0, 0, 0, 1, 0, 16'h0000, 5, 0, 0, 0, 0, 0, 0, 1, 16'h0000, 2},  // R2 link line1
        '{0, 0, 0, 0, 2, 0, 16'h0000, 0, 1, 0, 0, 0, 0, 0, 1, 16'h0000, 2},  // R2 link line2 alone
        '{1, 0, 0, 0, 1, 2, 16'hA5A5, 0, 0, 1, 0, 5, 2, 1, 1, 16'hA5A5, 3},  // R3 head write
        '{1, 0, 0, 0, 2, 0, 16'h1234, 0, 0, 0, 0, 0, 0, 1, 1, 16'h1234, 5},  // R5 sole sharer
        '{2, 1, 7, 0, 1, 0, 16'h0000, 0, 0, 0, 0, 0, 0, 0, 1, 16'h0000, 9},  // R9 ack
        '{2, 0, 3, 6, 1, 1, 16'h0BEE, 0, 0, 1, 0, 5, 6, 0, 1, 16'h0BEE, 6},  // R6 forward
        '{2, 3, 4, 0, 1, 1, 16'h0000, 0, 0, 1, 4, 4, 2, 0, 1, 16'h0BEE, 10}, // R10 grant
        '{1, 0, 0, 0, 1, 3, 16'h7777, 0, 0, 1, 2, 0, 2, 1, 1, 16'h7777, 4},  // R4 via directory
        '{2, 0, 5, 6, 2, 3, 16'h0042, 0, 0, 1, 1, 6, 6, 1, 1, 16'h0042, 7},  // R7 tail acks
        '{2, 3, 3, 0, 1, 3, 16'h0000, 0, 0, 0, 0, 0, 0, 1, 1, 16'h7777, 10}, // R10 not head
        '{0, 0, 0, 0, 3, 0, 16'h0000, 0, 1, 0, 0, 0, 0, 1, 1, 16'h0000, 2},  // R2 link line3
        '{2, 3, 1, 0, 3, 0, 16'h0000, 0, 0, 1, 4, 1, 2, 1, 1, 16'h0000, 10}, // R10 grant line3
        '{1, 0, 0, 0, 3, 1, 16'h5555, 0, 0, 1, 2, 0, 2, 2, 1, 16'h5555, 4},  // R4 tail writer
        '{2, 0, 4, 2, 3, 1, 16'h5555, 0, 0, 0, 0, 0, 0, 1, 1, 16'h5555, 8},  // R8 own update back
        '{2, 1, 5, 0, 3, 1, 16'h0000, 0, 0, 0, 0, 0, 0, 0, 1, 16'h5555, 9},  // R9 back to zero
        '{1, 0, 0, 0, 0, 2, 16'hBEEF, 0, 0, 0, 0, 0, 0, 0, 0, 16'h0000, 11}, // R11 write absent
        '{2, 0, 3, 6, 0, 2, 16'h1111, 0, 0, 0, 0, 0, 0, 0, 0, 16'h0000, 11}  // R11 update absent
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        link_valid = 1'b0, link_alone = 1'b0;
    logic [1:0]  link_line = '0;
    logic [2:0]  link_next = '0;
    logic        wr_valid = 1'b0;
    logic        wr_ready;
    logic [1:0]  wr_line = '0, wr_off = '0;
    logic [15:0] wr_data = '0;
    logic [1:0]  rd_line = '0, rd_off = '0;
    logic        rd_valid;
    logic [15:0] rd_data;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [2:0]  in_kind = '0, in_src = '0, in_origin = '0;
    logic [1:0]  in_line = '0, in_off = '0;
    logic [15:0] in_data = '0;
    logic        out_valid;
    logic [2:0]  out_kind, out_dst, out_origin;
    logic [1:0]  out_line, out_off;
    logic [15:0] out_data;
    logic [2:0]  pending;
    logic        performed;

    int n_chk = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    sharer_node u_sharer_node (
        .clk(clk), .rst_n(rst_n),
        .link_valid(link_valid), .link_line(link_line),
        .link_next(link_next), .link_alone(link_alone),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_line(wr_line),
        .wr_off(wr_off), .wr_data(wr_data),
        .rd_line(rd_line), .rd_off(rd_off), .rd_valid(rd_valid), .rd_data(rd_data),
        .in_valid(in_valid), .in_ready(in_ready), .in_kind(in_kind),
        .in_src(in_src), .in_origin(in_origin), .in_line(in_line),
        .in_off(in_off), .in_data(in_data),
        .out_valid(out_valid), .out_kind(out_kind), .out_dst(out_dst),
        .out_origin(out_origin), .out_line(out_line), .out_off(out_off),
        .out_data(out_data), .pending(pending), .performed(performed)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic run_vec(input vec_t v, input int idx);
        string req;
        req = $sformatf("R%0d(vec %0d)", v.rq, idx);
        @(negedge clk);
        rd_line = v.line;
        rd_off  = v.off;
        case (v.op)
            2'd0: begin
                link_valid = 1'b1; link_line = v.line;
                link_next = v.nxt; link_alone = v.alone;
            end
            2'd1: begin
                wr_valid = 1'b1; wr_line = v.line; wr_off = v.off; wr_data = v.data;
            end
            default: begin
                in_valid = 1'b1; in_kind = v.kind; in_src = v.src;
                in_origin = v.origin; in_line = v.line; in_off = v.off; in_data = v.data;
            end
        endcase
        @(posedge clk);
        @(negedge clk);
        link_valid = 1'b0;
        wr_valid = 1'b0;
        in_valid = 1'b0;
        @(posedge clk);
        @(negedge clk);
        chk(req, "out_valid", 32'(out_valid), 32'(v.exp_out));
        if (v.exp_out) begin
            chk(req, "out_kind",   32'(out_kind),   32'(v.exp_kind));
            chk(req, "out_dst",    32'(out_dst),    32'(v.exp_dst));
            chk(req, "out_origin", 32'(out_origin), 32'(v.exp_org));
            chk(req, "out_line",   32'(out_line),   32'(v.line));
            chk(req, "out_off",    32'(out_off),    32'(v.off));
            chk(req, "out_data",   32'(out_data),   32'(v.data));
        end
        chk(req, "pending",   32'(pending),   32'(v.exp_pend));
        chk(req, "performed", 32'(performed), 32'(v.exp_pend == 3'd0));
        chk(req, "rd_valid",  32'(rd_valid),  32'(v.exp_rdv));
        if (v.exp_rdv) chk(req, "rd_data", 32'(rd_data), 32'(v.exp_rd));
        @(posedge clk);
        @(negedge clk);
        chk("R12 drain", "out_valid", 32'(out_valid), 32'd0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        chk("R1", "out_valid", 32'(out_valid), 32'd0);
        chk("R1", "pending",   32'(pending),   32'd0);
        chk("R1", "performed", 32'(performed), 32'd1);
        chk("R1", "in_ready",  32'(in_ready),  32'd1);
        chk("R1", "wr_ready",  32'(wr_ready),  32'd1);
        for (int l = 0; l < 4; l++) begin
            rd_line = 2'(l);
            #1 chk("R1", "rd_valid", 32'(rd_valid), 32'd0);
        end
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) run_vec(VECS[i], i);

        // R12: inbound message blocks local writes, then the node is busy
        @(negedge clk);
        in_valid = 1'b1; in_kind = 3'd3; in_src = 3'd4; in_line = 2'd0; in_off = 2'd0;
        wr_valid = 1'b1; wr_line = 2'd1; wr_off = 2'd0; wr_data = 16'hFFFF;
        #1 chk("R12", "wr_ready with in_valid", 32'(wr_ready), 32'd0);
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        wr_valid = 1'b0;
        chk("R12", "in_ready while busy", 32'(in_ready), 32'd0);
        @(posedge clk);
        @(negedge clk);
        chk("R12", "in_ready back", 32'(in_ready), 32'd1);
        chk("R12", "out_valid", 32'(out_valid), 32'd0);
        rd_line = 2'd1; rd_off = 2'd0;
        #1 chk("R11", "rd_data untouched", 32'(rd_data), 32'd0);

        // R2: relinking a line clears its stored words
        @(negedge clk);
        link_valid = 1'b1; link_line = 2'd1; link_next = 3'd6; link_alone = 1'b0;
        @(posedge clk);
        @(negedge clk);
        link_valid = 1'b0;
        rd_line = 2'd1; rd_off = 2'd3;
        #1 chk("R2", "relink clears word", 32'(rd_data), 32'd0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog R12 actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule